// File: doc/BRIEF.md
# Buffered UART Transmitter with Empty-Slot Watermark

This block is the transmit half of an asynchronous serial port. A host pushes characters through a write strobe into an eight-entry byte queue. A shift stage takes them out one at a time and drives them onto a single serial line. Each bit lasts from one pulse of an external baud-tick input to the next pulse, so the block holds no rate divider of its own. Four character formats are available: plain 8-bit, 8-bit with even parity, 8-bit with odd parity, and 9-bit with an address-marker bit. One or two stop bits can be chosen. The line level can be inverted.

The host sees queue-full and queue-empty status, a level interrupt that rises once enough slots are free, a sticky flag for writes that were lost, and a flag that reports the whole path as drained. A break command sends a long low period on the line between characters. When the path is idle, a write skips the queue and goes straight into the shift stage, which keeps latency low.

Top module: `uart_txw`

## Requirements
- R1: The queue holds up to 8 characters. `fifo_full` is high exactly when 8 are held and `fifo_empty` is high exactly when none are held. Both flags are evaluated after reset, where the queue is empty.
- R2: A write while `fifo_full` is high is discarded and sets `collision`. The flag stays set until reset.
- R3: If the shift stage is idle, no break is pending, the queue is empty and `tx_en` is high, a write loads the shift stage directly and the queue stays empty.
- R4: A loaded character keeps the line at idle until the next `baud_tick`. After that, the line changes only in the clock cycle that follows a `baud_tick`, so each bit lasts from one tick to the next.
- R5: A frame is a low start bit, then the 8 data bits least significant first, then an optional 9th bit, then one stop bit (high), or two stop bits when `stop2`=1. A queued character follows the last stop bit with no idle gap.
- R6: `fmt`=01 adds an even-parity bit, so the count of ones over data plus parity is even. `fmt`=10 adds an odd-parity bit, so that count is odd. `fmt`=00 adds no 9th bit.
- R7: `fmt`=11 sends `wr_mark` as the 9th bit, where 1 marks an address character.
- R8: `tx_irq` is high exactly when the number of free slots (8 minus the characters held) is at least `wm_lvl`+1.
- R9: A `break_req` pulse holds the line low for 13 bit times. The break is sent after the current frame ends and before any queued character.
- R10: With `invert`=1, every level on `tx_line`, idle included, is the complement of the normal level.
- R11: `tsr_empty` is high exactly when the shift stage has finished its last bit and the queue is empty.
- R12: With `tx_en` low, no new character is taken from the queue and none bypasses it. A frame already in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Permits new characters to start |
| fmt | input | 2 | Character format: 00 plain, 01 even parity, 10 odd parity, 11 address bit |
| stop2 | input | 1 | 1 selects two stop bits |
| invert | input | 1 | Inverts the line level |
| wm_lvl | input | 3 | Free-slot threshold minus one |
| break_req | input | 1 | Pulse requesting a 13-bit break |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Character data |
| wr_mark | input | 1 | 9th bit value in address format |
| fifo_full | output | 1 | Queue holds 8 characters |
| fifo_empty | output | 1 | Queue holds no character |
| tx_irq | output | 1 | Free-slot watermark reached |
| collision | output | 1 | Sticky lost-write flag |
| tsr_empty | output | 1 | Shift stage and queue both empty |
| tx_line | output | 1 | Serial output |

## Verification
Two cases can arise in the same clock edge, and both are covered. In the first, a write arrives while the queue is full on the same edge where the end of a frame pops a character. The bench holds the write strobe high with the queue full across a frame boundary, and the write must still be dropped and flagged, because fullness is judged before the pop. In the second, a break request is pending at the end of a frame while characters are still queued. The break must win, and the queued characters must follow the 13 low bits. A behavioural model compares every output on every clock, so any slip in ordering or timing at these boundaries shows up as a mismatch.

// File: rtl/uart_txw_pkg.sv
package uart_txw_pkg;

    localparam int TXW_DATA_W  = 8;
    localparam int TXW_FRAME_W = 13;          // start + 8 data + ext + up to 2 stops, or break
    localparam int TXW_BRK_LEN = 13;
    localparam int TXW_CNT_W   = $clog2(TXW_FRAME_W + 1);

    typedef enum logic [1:0] {
        FMT_PLAIN = 2'b00,
        FMT_EVEN  = 2'b01,
        FMT_ODD   = 2'b10,
        FMT_ADDR  = 2'b11
    } txw_fmt_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SHIFT = 2'd2
    } txw_state_e;

    typedef struct packed {
        logic                  mark;
        logic [TXW_DATA_W-1:0] data;
    } txw_char_t;

    // Bit 0 goes out first; positions past the frame length are ones.
    function automatic logic [TXW_FRAME_W-1:0] txw_frame(txw_char_t c, txw_fmt_e f);
        logic ext;
        case (f)
            FMT_EVEN: ext = ^c.data;
            FMT_ODD:  ext = ~^c.data;
            FMT_ADDR: ext = c.mark;
            default:  ext = 1'b1;
        endcase
        return {3'b111, ext, c.data, 1'b0};
    endfunction

    function automatic logic [TXW_CNT_W-1:0] txw_len(txw_fmt_e f, logic two_stop);
        logic [TXW_CNT_W-1:0] n;
        n = TXW_CNT_W'(1 + TXW_DATA_W + 1);
        if (f != FMT_PLAIN) n = n + TXW_CNT_W'(1);
        if (two_stop)       n = n + TXW_CNT_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/uart_txw_fifo.sv
module uart_txw_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/uart_txw_wmark.sv
module uart_txw_wmark #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int LW   = $clog2(DEPTH)
) (
    input  logic [CW-1:0] count,
    input  logic [LW-1:0] level,
    output logic          irq
);
    logic [CW-1:0] free_slots;
    logic [CW-1:0] threshold;

    always_comb begin
        free_slots = CW'(DEPTH) - count;
        threshold  = CW'(level) + CW'(1);
        irq        = (free_slots >= threshold);
    end
endmodule

// File: rtl/uart_txw_shifter.sv
module uart_txw_shifter
    import uart_txw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tx_en,
    input  logic      baud_tick,
    input  logic      break_req,
    input  txw_fmt_e  fmt,
    input  logic      stop2,
    input  logic      q_empty,
    input  txw_char_t q_head,
    input  logic      wr_en,
    input  txw_char_t wr_char,
    output logic      q_pop,
    output logic      bypass,
    output logic      idle,
    output logic      line_raw
);
    txw_state_e             state;
    logic [TXW_FRAME_W-1:0] frame;
    logic [TXW_CNT_W-1:0]   bits_left;
    logic                   brk_pend;
    logic                   load_chr;
    logic                   load_brk;
    logic                   last_bit;
    txw_char_t              src;

    assign last_bit = baud_tick && (bits_left == TXW_CNT_W'(1));

    always_comb begin
        q_pop    = 1'b0;
        bypass   = 1'b0;
        load_chr = 1'b0;
        load_brk = 1'b0;
        src      = q_head;
        case (state)
            SH_IDLE: begin
                if (brk_pend) begin
                    load_brk = 1'b1;
                end else if (tx_en && !q_empty) begin
                    q_pop    = 1'b1;
                    load_chr = 1'b1;
                end else if (tx_en && wr_en) begin
                    bypass   = 1'b1;
                    load_chr = 1'b1;
                    src      = wr_char;
                end
            end
            SH_SHIFT: begin
                if (last_bit && !brk_pend && tx_en && !q_empty) begin
                    q_pop    = 1'b1;
                    load_chr = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SH_IDLE;
            frame     <= '1;
            bits_left <= '0;
            brk_pend  <= 1'b0;
        end else begin
            brk_pend <= break_req | (brk_pend & ~load_brk);
            case (state)
                SH_IDLE: begin
                    if (load_brk) begin
                        frame     <= '0;
                        bits_left <= TXW_CNT_W'(TXW_BRK_LEN);
                        state     <= SH_ARMED;
                    end else if (load_chr) begin
                        frame     <= txw_frame(src, fmt);
                        bits_left <= txw_len(fmt, stop2);
                        state     <= SH_ARMED;
                    end
                end
                SH_ARMED: begin
                    if (baud_tick) state <= SH_SHIFT;
                end
                SH_SHIFT: begin
                    if (last_bit) begin
                        if (load_chr) begin
                            frame     <= txw_frame(src, fmt);
                            bits_left <= txw_len(fmt, stop2);
                        end else begin
                            frame <= '1;
                            state <= SH_IDLE;
                        end
                    end else if (baud_tick) begin
                        frame     <= {1'b1, frame[TXW_FRAME_W-1:1]};
                        bits_left <= bits_left - TXW_CNT_W'(1);
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    assign idle     = (state == SH_IDLE);
    assign line_raw = (state == SH_SHIFT) ? frame[0] : 1'b1;
endmodule

// File: rtl/uart_txw.sv
module uart_txw
    import uart_txw_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_en,
    input  logic [1:0]            fmt,
    input  logic                  stop2,
    input  logic                  invert,
    input  logic [LW-1:0]         wm_lvl,
    input  logic                  break_req,
    input  logic                  baud_tick,
    input  logic                  wr_en,
    input  logic [TXW_DATA_W-1:0] wr_data,
    input  logic                  wr_mark,
    output logic                  fifo_full,
    output logic                  fifo_empty,
    output logic                  tx_irq,
    output logic                  collision,
    output logic                  tsr_empty,
    output logic                  tx_line
);
    txw_char_t     wr_char, q_head;
    logic [CW-1:0] q_count;
    logic          q_pop, q_push, bypass, sh_idle, line_raw;

    assign wr_char = '{mark: wr_mark, data: wr_data};
    assign q_push  = wr_en && !fifo_full && !bypass;

    uart_txw_fifo #(.DEPTH(DEPTH), .W($bits(txw_char_t))) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .push      (q_push),
        .push_data (wr_char),
        .pop       (q_pop),
        .head      (q_head),
        .count     (q_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_txw_shifter shifter_i (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .break_req (break_req),
        .fmt       (txw_fmt_e'(fmt)),
        .stop2     (stop2),
        .q_empty   (fifo_empty),
        .q_head    (q_head),
        .wr_en     (wr_en),
        .wr_char   (wr_char),
        .q_pop     (q_pop),
        .bypass    (bypass),
        .idle      (sh_idle),
        .line_raw  (line_raw)
    );

    uart_txw_wmark #(.DEPTH(DEPTH)) wmark_i (
        .count (q_count),
        .level (wm_lvl),
        .irq   (tx_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)                       collision <= 1'b0;
        else if (wr_en && fifo_full)   collision <= 1'b1;
    end

    assign tsr_empty = sh_idle && fifo_empty;
    assign tx_line   = line_raw ^ invert;
endmodule

// File: rtl/uart_txw_chk.sv
module uart_txw_chk (
    input logic clk,
    input logic rst,
    input logic baud_tick,
    input logic invert,
    input logic fifo_full,
    input logic fifo_empty,
    input logic tx_irq,
    input logic collision,
    input logic tsr_empty,
    input logic tx_line
);
    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    p_collision_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        collision |=> collision);

    p_line_moves_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> ($stable(tx_line) || !$stable(invert)));

    p_irq_when_drained_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> tx_irq);

    p_no_irq_when_full_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !tx_irq);

    p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
        tsr_empty |-> (tx_line == !invert));

    p_drained_means_empty_r11: assert property (@(posedge clk) disable iff (rst)
        tsr_empty |-> fifo_empty);
endmodule

bind uart_txw uart_txw_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .invert     (invert),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .tx_irq     (tx_irq),
    .collision  (collision),
    .tsr_empty  (tsr_empty),
    .tx_line    (tx_line)
);

// File: tb/uart_txw_tb_top.sv
module uart_txw_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst = 1'b1, tx_en = 1'b0, stop2 = 1'b0, invert = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic [2:0] wm_lvl = 3'd0;
    logic       break_req = 1'b0, baud_tick = 1'b0, wr_en = 1'b0, wr_mark = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full, fifo_empty, tx_irq, collision, tsr_empty, tx_line;

    uart_txw dut_i (
        .clk(clk), .rst(rst), .tx_en(tx_en), .fmt(fmt), .stop2(stop2),
        .invert(invert), .wm_lvl(wm_lvl), .break_req(break_req),
        .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .wr_mark(wr_mark), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .tx_irq(tx_irq), .collision(collision), .tsr_empty(tsr_empty),
        .tx_line(tx_line)
    );

    // Behavioural reference: character queue plus a queue of pending line bits.
    logic [8:0] m_q[$];
    bit         m_bits[$];
    int         m_st;        // 0 idle, 1 waiting for tick, 2 sending
    bit         m_brk, m_coll;
    string      m_tag = "R5";

    int checks = 0, fails = 0, cyc = 0;
    bit tick_on = 1'b1, comparing = 1'b0, done = 1'b0;

    function void build_bits(logic [8:0] ch);
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_bits.push_back(ch[i]);
        if (fmt == 2'b01)      begin m_bits.push_back(^ch[7:0]);  m_tag = "R6"; end
        else if (fmt == 2'b10) begin m_bits.push_back(~^ch[7:0]); m_tag = "R6"; end
        else if (fmt == 2'b11) begin m_bits.push_back(ch[8]);     m_tag = "R7"; end
        else m_tag = "R5";
        m_bits.push_back(1'b1);
        if (stop2) m_bits.push_back(1'b1);
    endfunction

    always @(posedge clk) begin : model
        int pre;
        bit byp;
        if (rst) begin
            m_q.delete(); m_bits.delete();
            m_st = 0; m_brk = 0; m_coll = 0;
        end else begin
            pre = m_q.size();
            byp = 0;
            case (m_st)
                0: begin
                    if (m_brk) begin
                        m_bits.delete();
                        repeat (13) m_bits.push_back(1'b0);
                        m_st = 1; m_brk = 0; m_tag = "R9";
                    end else if (tx_en && pre > 0) begin
                        build_bits(m_q.pop_front()); m_st = 1;
                    end else if (tx_en && wr_en) begin
                        build_bits({wr_mark, wr_data}); m_st = 1; byp = 1;
                        m_tag = {m_tag, "/R3"};
                    end
                end
                1: if (baud_tick) m_st = 2;
                default: if (baud_tick) begin
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) begin
                        if (!m_brk && tx_en && pre > 0) build_bits(m_q.pop_front());
                        else m_st = 0;
                    end
                end
            endcase
            if (wr_en && !byp) begin
                if (pre == 8) m_coll = 1;
                else m_q.push_back({wr_mark, wr_data});
            end
            if (break_req) m_brk = 1;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic check_all();
        string t;
        logic  exp_line;
        exp_line = ((m_st == 2) ? m_bits[0] : 1'b1) ^ invert;
        t = (m_st == 1) ? "R4" : m_tag;
        if (invert) t = {t, "/R10"};
        if (!tx_en && m_q.size() > 0) t = {t, "/R12"};
        chk("R1 fifo_full", fifo_full, m_q.size() == 8);
        chk("R1 fifo_empty", fifo_empty, m_q.size() == 0);
        chk("R2 collision", collision, m_coll);
        chk("R8 tx_irq", tx_irq, (8 - m_q.size()) >= (int'(wm_lvl) + 1));
        chk("R11 tsr_empty", tsr_empty, (m_st == 0) && (m_q.size() == 0));
        chk({t, " tx_line"}, tx_line, exp_line);
    endtask

    task automatic step();
        @(negedge clk);
        if (comparing) check_all();
        cyc++;
        baud_tick = tick_on && (cyc % TICK_DIV == 0);
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    task automatic put(logic [7:0] d, logic m);
        step();
        wr_en = 1'b1; wr_data = d; wr_mark = m;
        step();
        wr_en = 1'b0;
    endtask

    task automatic finish_report();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        comparing = 1'b1;
        run(2);                       // R1 reset state: empty, idle line
        rst = 1'b0;
        run(10);

        // R3/R5: single plain byte bypasses the queue
        tx_en = 1'b1;
        put(8'hA5, 1'b0);
        run(60);

        // R4: no ticks, loaded byte must wait at idle
        tick_on = 1'b0;
        put(8'h3C, 1'b0);
        run(25);
        tick_on = 1'b1;
        run(60);

        // R1/R2/R8/R12: fill with transmitter off, overflow, sweep watermark
        tx_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            put(8'h10 + 8'(i), 1'b0);
            wm_lvl = 3'(i);
        end
        for (int k = 0; k < 8; k++) begin
            wm_lvl = 3'(k);
            run(2);
        end
        // R6 even parity, two stop bits, drain
        fmt = 2'b01; stop2 = 1'b1; tx_en = 1'b1; wm_lvl = 3'd3;
        for (int k = 0; k < 10; k++) begin
            run(50);
            wm_lvl = 3'(k);
        end

        // R6 odd parity, back-to-back frames
        fmt = 2'b10; stop2 = 1'b0;
        put(8'h00, 1'b0); put(8'hFF, 1'b0); put(8'h81, 1'b0);
        run(200);

        // R7 address bit, R10 inversion
        fmt = 2'b11; invert = 1'b1;
        put(8'h42, 1'b1); put(8'h42, 1'b0); put(8'hC3, 1'b1);
        run(180);

        // R9 break during a frame with a queued byte, then from idle
        fmt = 2'b00; invert = 1'b0;
        put(8'h5A, 1'b0); put(8'h96, 1'b0);
        run(8);
        break_req = 1'b1; step(); break_req = 1'b0;
        run(220);
        break_req = 1'b1; step(); break_req = 1'b0;
        run(80);

        // R12: disable mid-frame, queued bytes held
        put(8'h11, 1'b0); put(8'h22, 1'b0); put(8'h33, 1'b0);
        run(12);
        tx_en = 1'b0;
        run(100);
        tx_en = 1'b1;
        run(150);

        // R2: write held high while full across a frame boundary
        for (int i = 0; i < 80; i++) begin
            wr_en = 1'b1; wr_data = 8'h60 + 8'(i); wr_mark = 1'b0;
            step();
        end
        wr_en = 1'b0;
        run(500);

        finish_report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            finish_report();
        end
    end
endmodule